// File: doc/BRIEF.md
# Dual-Channel DDR I/Q Receive Deframer

This block sits between the receive data port of an RF transceiver and the radio datapath. The transceiver sends a 12-bit bus at double data rate together with a frame marker, both timed by its own source clock. On each rising edge of that clock the bus carries an I sample, and on the falling edge that follows it carries the matching Q sample. The deframer captures both halves and uses the frame marker to pair them up. It then presents parallel I and Q words for two receive channels and pulses a strobe when a complete sample set is ready. The radio clock domain of the outputs is the forwarded source clock, `ddr_clk`.

With `dual_mode` low, one channel is on the bus. The frame marker is high for the I half and low for the Q half, and every accepted pair is written to both channel outputs. With `dual_mode` high, two channels share the bus. A cycle whose frame marker is high on both halves carries channel 0, and the following cycle, with the marker low on both halves, carries channel 1. Alignment is taken from the first low-to-high step of the frame marker after reset, so a partial sample that arrives while the deframer is coming out of reset never reaches the outputs. An asynchronous reset input is synchronised into the clock domain. It is also brought out as a reset for the radio logic.

Top module: `ddr_iq_rx_deframer`

## Requirements
- R1: `rst_sync_out` goes high as soon as `areset_in` is high, without waiting for a clock. After `areset_in` falls, `rst_sync_out` stays high through the next rising edge of `ddr_clk` and falls on the second rising edge.
- R2: While `rst_sync_out` is high, all four channel words are zero and `sample_stb` is low.
- R3: The word sampled on a rising edge of `ddr_clk` is the I sample and the word sampled on the falling edge that follows it is the Q sample. A pair whose I half is sampled at rising edge n is written to the outputs at rising edge n+1.
- R4: After reset, no pair is accepted until a falling-edge half with the frame marker low is directly followed by a rising-edge half with the marker high. The pair that starts with that rising-edge half is the first one that can be accepted, and alignment is kept until the next reset.
- R5: With `dual_mode` = 0, an aligned pair with the frame marker high on the rising half and low on the falling half writes I to `rx0_i` and `rx1_i` and Q to `rx0_q` and `rx1_q`, and `sample_stb` is high for that one cycle.
- R6: With `dual_mode` = 1, an aligned pair with the frame marker high on both halves writes `rx0_i`/`rx0_q`. It leaves channel 1 unchanged and does not raise `sample_stb`. If two such pairs arrive in a row, the second one overwrites the first.
- R7: With `dual_mode` = 1, a pair with the frame marker low on both halves that directly follows a channel 0 pair writes `rx1_i`/`rx1_q` and raises `sample_stb` for one cycle. Channel 0 is left unchanged, so in this mode `sample_stb` is never high on two cycles in a row.
- R8: Any other pair leaves all four words unchanged and `sample_stb` low. This covers a frame marker of low-then-high in either mode, high-then-low in dual mode, high-high or low-low in single mode, low-low in dual mode that does not follow a channel 0 pair, and any pair arriving before alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| areset_in | input | 1 | Asynchronous reset, active high |
| dual_mode | input | 1 | 0: single channel copied to both outputs; 1: two interleaved channels |
| ddr_clk | input | 1 | Transceiver source clock; also the radio clock of the outputs |
| ddr_frame | input | 1 | Frame marker, sampled on both clock edges |
| ddr_data | input | DATA_W (12) | Double-data-rate sample bus |
| rst_sync_out | output | 1 | Reset synchronised to `ddr_clk` |
| rx0_i | output | DATA_W | Channel 0 I word |
| rx0_q | output | DATA_W | Channel 0 Q word |
| rx1_i | output | DATA_W | Channel 1 I word |
| rx1_q | output | DATA_W | Channel 1 Q word |
| sample_stb | output | 1 | One-cycle pulse when a complete sample set is valid |

## Verification
The bench checks the first aligned pair after each reset. It must be dropped in single mode, and in dual mode the first high-high cycle must be dropped. A design that locked on the frame level instead of the low-to-high step would pass a stale half-sample to the outputs. The bench also injects frame patterns that break the rules: a lone low-low cycle, a high-then-low pair in dual mode, and repeated channel 0 cycles. A design that decoded these wrongly would write channel 1 out of turn or strobe twice in a row. The bench changes mode mid-stream and resets mid-stream with non-zero outputs, which exposes state that is not cleared and outputs that clear only on a clock edge. Boundary data words (all ones, all zeros, only the top bit set) catch a swap of I and Q or a lost bit.

// File: rtl/rdf_pkg.sv
`timescale 1ns/1ps
package rdf_pkg;

   localparam int RDF_WORD_W = 12;

   // Decoded meaning of one captured rising/falling pair
   typedef enum logic [1:0] {
      PK_NONE   = 2'd0,
      PK_SINGLE = 2'd1,
      PK_CH0    = 2'd2,
      PK_CH1    = 2'd3
   } pair_kind_e;

   function automatic pair_kind_e rdf_classify(
      input logic rise_hi,
      input logic fall_hi,
      input logic dual,
      input logic aligned,
      input logic ch0_pend
   );
      pair_kind_e k;
      k = PK_NONE;
      if (!dual) begin
         if (rise_hi && !fall_hi && aligned) k = PK_SINGLE;
      end else if (rise_hi && fall_hi && aligned) begin
         k = PK_CH0;
      end else if (!rise_hi && !fall_hi && ch0_pend) begin
         k = PK_CH1;
      end
      return k;
   endfunction

endpackage

// File: rtl/rdf_rst_sync.sv
`timescale 1ns/1ps
module rdf_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst,
   output logic rst_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("rdf_rst_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or posedge arst) begin
      if (arst) chain <= '1;
      else      chain <= {chain[STAGES-2:0], 1'b0};
   end

   assign rst_out = chain[STAGES-1];

endmodule

// File: rtl/rdf_ddr_capture.sv
`timescale 1ns/1ps
module rdf_ddr_capture #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         frame,
   input  logic [W-1:0] data,
   output logic [W-1:0] rise_word,
   output logic         rise_frm,
   output logic [W-1:0] fall_word,
   output logic         fall_frm
);

   if (W < 1) begin : g_bad_width
      $error("rdf_ddr_capture: W must be positive");
   end

   // Rising half: I sample
   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         rise_word <= '0;
         rise_frm  <= 1'b0;
      end else begin
         rise_word <= data;
         rise_frm  <= frame;
      end
   end

   // Falling half: Q sample; frame resets high so no false edge is seen
   always_ff @(negedge clk or posedge rst) begin
      if (rst) begin
         fall_word <= '0;
         fall_frm  <= 1'b1;
      end else begin
         fall_word <= data;
         fall_frm  <= frame;
      end
   end

endmodule

// File: rtl/rdf_deframer.sv
`timescale 1ns/1ps
module rdf_deframer
   import rdf_pkg::*;
#(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         dual,
   input  logic [W-1:0] rise_word,
   input  logic         rise_frm,
   input  logic [W-1:0] fall_word,
   input  logic         fall_frm,
   output logic [W-1:0] o0_i,
   output logic [W-1:0] o0_q,
   output logic [W-1:0] o1_i,
   output logic [W-1:0] o1_q,
   output logic         stb
);

   logic       prev_fall;
   logic       locked;
   logic       ch0_pend;
   logic       step_up;
   pair_kind_e kind;

   always_comb begin
      step_up = !prev_fall && rise_frm;
      kind    = rdf_classify(rise_frm, fall_frm, dual, locked || step_up, ch0_pend);
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         prev_fall <= 1'b1;
         locked    <= 1'b0;
         ch0_pend  <= 1'b0;
         stb       <= 1'b0;
         o0_i      <= '0;
         o0_q      <= '0;
         o1_i      <= '0;
         o1_q      <= '0;
      end else begin
         prev_fall <= fall_frm;
         if (step_up) locked <= 1'b1;
         stb      <= 1'b0;
         ch0_pend <= 1'b0;
         case (kind)
            PK_SINGLE: begin
               o0_i <= rise_word;
               o0_q <= fall_word;
               o1_i <= rise_word;
               o1_q <= fall_word;
               stb  <= 1'b1;
            end
            PK_CH0: begin
               o0_i     <= rise_word;
               o0_q     <= fall_word;
               ch0_pend <= 1'b1;
            end
            PK_CH1: begin
               o1_i <= rise_word;
               o1_q <= fall_word;
               stb  <= 1'b1;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/ddr_iq_rx_deframer.sv
`timescale 1ns/1ps
module ddr_iq_rx_deframer #(
   parameter int DATA_W      = rdf_pkg::RDF_WORD_W,
   parameter int SYNC_STAGES = 2
) (
   input  logic              areset_in,
   input  logic              dual_mode,
   input  logic              ddr_clk,
   input  logic              ddr_frame,
   input  logic [DATA_W-1:0] ddr_data,
   output logic              rst_sync_out,
   output logic [DATA_W-1:0] rx0_i,
   output logic [DATA_W-1:0] rx0_q,
   output logic [DATA_W-1:0] rx1_i,
   output logic [DATA_W-1:0] rx1_q,
   output logic              sample_stb
);

   if (DATA_W < 2) begin : g_bad_data_w
      $error("ddr_iq_rx_deframer: DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] rise_word;
   logic [DATA_W-1:0] fall_word;
   logic              rise_frm;
   logic              fall_frm;

   rdf_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
      .clk     (ddr_clk),
      .arst    (areset_in),
      .rst_out (rst_sync_out)
   );

   rdf_ddr_capture #(.W(DATA_W)) u_cap (
      .clk       (ddr_clk),
      .rst       (rst_sync_out),
      .frame     (ddr_frame),
      .data      (ddr_data),
      .rise_word (rise_word),
      .rise_frm  (rise_frm),
      .fall_word (fall_word),
      .fall_frm  (fall_frm)
   );

   rdf_deframer #(.W(DATA_W)) u_dfr (
      .clk       (ddr_clk),
      .rst       (rst_sync_out),
      .dual      (dual_mode),
      .rise_word (rise_word),
      .rise_frm  (rise_frm),
      .fall_word (fall_word),
      .fall_frm  (fall_frm),
      .o0_i      (rx0_i),
      .o0_q      (rx0_q),
      .o1_i      (rx1_i),
      .o1_q      (rx1_q),
      .stb       (sample_stb)
   );

endmodule

// File: rtl/rdf_checker.sv
`timescale 1ns/1ps
module rdf_checker #(
   parameter int W = 12
) (
   input logic         clk,
   input logic         arst,
   input logic         rst,
   input logic         dual,
   input logic [W-1:0] i0,
   input logic [W-1:0] q0,
   input logic [W-1:0] i1,
   input logic [W-1:0] q1,
   input logic         stb
);

   a_r1_assert_async: assert property (@(posedge clk)
      arst |-> rst);

   a_r1_release_after_low: assert property (@(posedge clk) disable iff (arst)
      $fell(rst) |-> !$past(arst));

   a_r2_zero_in_reset: assert property (@(posedge clk)
      rst |-> (i0 == '0 && q0 == '0 && i1 == '0 && q1 == '0 && !stb));

   a_r5_single_copies: assert property (@(posedge clk) disable iff (rst)
      (stb && !$past(dual)) |-> (i1 == i0 && q1 == q0));

   a_r7_ch0_held_on_stb: assert property (@(posedge clk) disable iff (rst)
      (stb && $past(dual)) |-> ($stable(i0) && $stable(q0)));

   a_r7_stb_spacing: assert property (@(posedge clk) disable iff (rst)
      (dual && stb) |=> !stb);

   a_r8_ch1_only_with_stb: assert property (@(posedge clk) disable iff (rst)
      !stb |-> ($stable(i1) && $stable(q1)));

endmodule

bind ddr_iq_rx_deframer rdf_checker #(.W(DATA_W)) u_chk (
   .clk  (ddr_clk),
   .arst (areset_in),
   .rst  (rst_sync_out),
   .dual (dual_mode),
   .i0   (rx0_i),
   .q0   (rx0_q),
   .i1   (rx1_i),
   .q1   (rx1_q),
   .stb  (sample_stb)
);

// File: tb/sim_ddr_iq_rx_deframer.sv
`timescale 1ns/1ps
module sim_ddr_iq_rx_deframer;

   localparam int W = 12;

   logic         clk  = 1'b0;
   logic         arst = 1'b0;
   logic         dual = 1'b0;
   logic         frm  = 1'b0;
   logic [W-1:0] dat  = '0;
   logic         rst_o;
   logic [W-1:0] o0_i, o0_q, o1_i, o1_q;
   logic         stb;

   ddr_iq_rx_deframer #(.DATA_W(W), .SYNC_STAGES(2)) u0 (
      .areset_in    (arst),
      .dual_mode    (dual),
      .ddr_clk      (clk),
      .ddr_frame    (frm),
      .ddr_data     (dat),
      .rst_sync_out (rst_o),
      .rx0_i        (o0_i),
      .rx0_q        (o0_q),
      .rx1_i        (o1_i),
      .rx1_q        (o1_q),
      .sample_stb   (stb)
   );

   always #2.5 clk = ~clk;   // 200 MHz

   int checks = 0;
   int errors = 0;

   // Reference model state
   bit           model_on = 1'b0;
   bit           have_prev = 1'b0;
   logic [W-1:0] p_i, p_q;
   logic         p_fr, p_ff;
   logic         m_prev_fall, m_lock, m_pend, m_stb;
   logic [W-1:0] m0_i, m0_q, m1_i, m1_q;

   task automatic cmp(input string tag, input string name, input logic [W-1:0] act,
                      input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, name, act, exp, $time);
      end
   endtask

   task automatic cmp_all(input string tag);
      cmp(tag, "rx0_i", o0_i, m0_i);
      cmp(tag, "rx0_q", o0_q, m0_q);
      cmp(tag, "rx1_i", o1_i, m1_i);
      cmp(tag, "rx1_q", o1_q, m1_q);
      cmp(tag, "sample_stb", {{(W-1){1'b0}}, stb}, {{(W-1){1'b0}}, m_stb});
   endtask

   task automatic model_clear();
      m_prev_fall = 1'b1; m_lock = 1'b0; m_pend = 1'b0; m_stb = 1'b0;
      m0_i = '0; m0_q = '0; m1_i = '0; m1_q = '0;
   endtask

   // One radio clock of processing, from the requirement text
   task automatic model_step(input logic [W-1:0] wi, input logic [W-1:0] wq,
                             input logic fr, input logic ff);
      bit step_up, ok, was_pend;
      step_up  = !m_prev_fall && fr;          // R4
      ok       = m_lock || step_up;
      was_pend = m_pend;
      m_stb    = 1'b0;
      m_pend   = 1'b0;
      if (!dual) begin
         if (fr && !ff && ok) begin            // R5
            m0_i = wi; m0_q = wq; m1_i = wi; m1_q = wq; m_stb = 1'b1;
         end
      end else if (fr && ff && ok) begin       // R6
         m0_i = wi; m0_q = wq; m_pend = 1'b1;
      end else if (!fr && !ff && was_pend) begin // R7
         m1_i = wi; m1_q = wq; m_stb = 1'b1;
      end
      if (step_up) m_lock = 1'b1;
      m_prev_fall = ff;
   endtask

   // Drive one DDR cycle: I half then Q half, then check the previous pair
   task automatic send(input logic [W-1:0] wi, input logic [W-1:0] wq,
                       input logic fr, input logic ff, input string tag);
      @(negedge clk); #1; dat = wi; frm = fr;
      @(posedge clk); #1; dat = wq; frm = ff;
      if (model_on) begin
         if (have_prev) model_step(p_i, p_q, p_fr, p_ff);
         cmp_all(tag);
      end else begin
         cmp(tag, "rx0_i", o0_i, '0);
         cmp(tag, "rx1_q", o1_q, '0);
         cmp(tag, "sample_stb", {{(W-1){1'b0}}, stb}, '0);
      end
      p_i = wi; p_q = wq; p_fr = fr; p_ff = ff; have_prev = 1'b1;
   endtask

   task automatic do_reset();
      model_on = 1'b0;
      arst = 1'b1;
      #1;
      cmp("R1", "rst_sync_out async", {{(W-1){1'b0}}, rst_o}, 1);
      cmp("R2", "rx0_i in reset", o0_i, '0);
      cmp("R2", "rx0_q in reset", o0_q, '0);
      cmp("R2", "rx1_i in reset", o1_i, '0);
      cmp("R2", "sample_stb in reset", {{(W-1){1'b0}}, stb}, '0);
      send('0, '0, 1'b0, 1'b1, "R2");
      send('0, '0, 1'b0, 1'b1, "R2");
      arst = 1'b0;
      send('0, '0, 1'b0, 1'b1, "R2");
      cmp("R1", "rst_sync_out after 1 edge", {{(W-1){1'b0}}, rst_o}, 1);
      send('0, '0, 1'b0, 1'b1, "R2");
      cmp("R1", "rst_sync_out after 2 edges", {{(W-1){1'b0}}, rst_o}, 0);
      send('0, '0, 1'b0, 1'b1, "R8");
      send('0, '0, 1'b0, 1'b1, "R8");
      model_clear();
      model_on = 1'b1;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      #1;
      do_reset();

      // Single mode: first aligned pair after reset discarded, then accepted
      dual = 1'b0;
      for (int k = 0; k < 12; k++)
         send(W'((k * 37 + 5) % 4096), W'((k * 91 + 300) % 4096), 1'b1, 1'b0, "R3 R4 R5");
      send(12'hFFF, 12'h000, 1'b1, 1'b0, "R3");
      send(12'h800, 12'h001, 1'b1, 1'b0, "R3");
      send(12'h000, 12'hFFF, 1'b1, 1'b0, "R5");

      // Single mode: illegal frame patterns leave outputs untouched
      send(12'h123, 12'h456, 1'b0, 1'b1, "R8");
      send(12'h234, 12'h567, 1'b1, 1'b1, "R8");
      send(12'h345, 12'h678, 1'b0, 1'b0, "R8");
      send(12'h0AA, 12'h055, 1'b1, 1'b0, "R5");
      send(12'h0AA, 12'h055, 1'b1, 1'b0, "R5");

      // Dual mode, alignment kept from single mode
      dual = 1'b1;
      for (int k = 0; k < 8; k++) begin
         send(W'(k * 4 + 1), W'(k * 4 + 2), 1'b1, 1'b1, "R6");
         send(W'(k * 4 + 3), W'(k * 4 + 4), 1'b0, 1'b0, "R7");
      end

      // Dual mode corner patterns
      send(12'h111, 12'h222, 1'b0, 1'b0, "R8");   // low-low with no ch0 before
      send(12'h333, 12'h444, 1'b1, 1'b0, "R8");   // high-low in dual mode
      send(12'h555, 12'h666, 1'b0, 1'b0, "R8");
      send(12'h777, 12'h888, 1'b1, 1'b1, "R6");
      send(12'h999, 12'hAAA, 1'b1, 1'b1, "R6");   // second ch0 overwrites
      send(12'hBBB, 12'hCCC, 1'b0, 1'b0, "R7");
      send(12'hDDD, 12'hEEE, 1'b0, 1'b1, "R8");
      send(12'hFFF, 12'h800, 1'b1, 1'b1, "R6");
      send(12'h001, 12'h7FF, 1'b0, 1'b0, "R7");
      send(12'h002, 12'h003, 1'b0, 1'b0, "R8");

      // Reset mid-stream with non-zero outputs, relock in dual mode
      do_reset();
      for (int k = 0; k < 6; k++) begin
         send(W'(k * 100 + 7), W'(k * 100 + 8), 1'b1, 1'b1, "R4 R6");
         send(W'(k * 100 + 9), W'(k * 100 + 10), 1'b0, 1'b0, "R4 R7");
      end

      // Back to single mode
      dual = 1'b0;
      for (int k = 0; k < 6; k++)
         send(W'(4095 - k * 13), W'(k * 211), 1'b1, 1'b0, "R5");
      send('0, '0, 1'b1, 1'b0, "R5");
      send('0, '0, 1'b1, 1'b0, "R5");

      disable watchdog;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule